// File: doc/BRIEF.md
# Flash Pattern Sequencer

This block turns a single-cycle request into a fixed blinking pattern on one light output. Once triggered from its idle state, it produces a set number of lit intervals separated by dark gaps. After the last lit interval it drops straight back to idle with the light off, and it does not add a trailing gap.

The work is split between three cooperating pieces. A phase controller walks through idle, lit and gap states. A reloadable down-counting timer measures how long each phase lasts. A small counter holds how many lit intervals are still owed. The controller reloads the timer whenever the timer reports expiry, and also on every idle cycle. Each reload picks the duration of the phase that is about to begin, so the lit and gap lengths are each the reload value plus one. Requests that arrive while a pattern is running are dropped.

Top module: `flash_sequencer`

## Requirements
- R1: While reset is held and after its release, `light` is 0 and the block sits idle until a request arrives.
- R2: A `start` high in an idle cycle makes `light` go to 1 at the next rising clock edge. It then stays 1 for ON_LOAD+1 cycles (6 with defaults).
- R3: Between consecutive lit intervals, `light` is 0 for exactly GAP_LOAD+1 cycles (4 with defaults).
- R4: One request yields exactly NUM_FLASHES lit intervals (3 with defaults). After the last one the block returns to idle with `light` 0 and adds no gap. The whole pattern spans NUM_FLASHES*(ON_LOAD+1)+(NUM_FLASHES-1)*(GAP_LOAD+1) cycles, which is 26 with defaults.
- R5: A `start` seen in any cycle of a running pattern, including its final lit cycle, has no effect on `light`.
- R6: A `start` in the first idle cycle after a pattern ends begins a new pattern at once.
- R7: The phase timer follows three rules. A reload sets it to the selected value whatever its current count. If there is no reload and it has not expired, it counts down by one. Its expiry flag stays up until the next reload.
- R8: The remaining-flash counter is set to NUM_FLASHES-1 in idle. It is decremented only when a gap expires, and it is never decremented from zero.
- R9: Asserting `rst_n` low while a pattern runs forces `light` to 0 immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request to begin a flashing pattern |
| light | output | 1 | Light drive, high only during lit intervals |

## Verification
An isolated single pulse shows the exact lit and gap lengths and the count of lit intervals against an independent cycle model. Holding `start` high for many cycles separates a correct design from one that restarts mid-pattern: the output must repeat whole 26-cycle patterns separated by one idle cycle. A pulse placed in the first idle cycle after a pattern shows that the return to idle is immediate. Random pulse trains and an asynchronous reset mid-pattern cover how requests interleave and that an abort takes effect at once.

// File: rtl/flash_pkg.sv
package flash_pkg;

  // Phase controller states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LIT  = 2'd1,
    ST_GAP  = 2'd2
  } flash_state_e;

  // Timer reload selector encoding
  localparam logic SEL_GAP = 1'b0;
  localparam logic SEL_LIT = 1'b1;

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assertion is immediate, release travels through the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int LIT_LOAD = 5,
  parameter int GAP_LOAD = 3,
  parameter int TMR_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel,
  output logic done
);

  import flash_pkg::*;

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;
  logic             cnt_en;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = (sel == SEL_LIT) ? TMR_W'(LIT_LOAD) : TMR_W'(GAP_LOAD);
    end else if (!done) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R7: a reload lands the selected value
  p_reload_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == ($past(sel) ? TMR_W'(LIT_LOAD) : TMR_W'(GAP_LOAD))));

  // R7: expiry holds until the next reload
  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

  // R7: single-step countdown otherwise
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/flash_left_counter.sv
module flash_left_counter #(
  parameter int NUM_FLASHES = 3,
  parameter int CNT_W       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic none_left
);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] left_d;
  logic             left_en;

  assign none_left = (left_q == '0);

  always_comb begin
    left_en = 1'b0;
    left_d  = left_q;
    if (load) begin
      left_en = 1'b1;
      left_d  = CNT_W'(NUM_FLASHES - 1);
    end else if (dec) begin
      left_en = 1'b1;
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  // R8: never decremented from zero
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !none_left);

  // R8: decrement takes exactly one off
  p_dec_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (left_q == $past(left_q) - 1'b1));

  // R8: a load sets the full remaining count
  p_load_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left_q == CNT_W'(NUM_FLASHES - 1)));

endmodule

// File: rtl/flash_phase_ctrl.sv
module flash_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tmr_done,
  input  logic none_left,
  output logic tmr_load,
  output logic tmr_sel,
  output logic cnt_load,
  output logic cnt_dec,
  output logic light
);

  import flash_pkg::*;

  flash_state_e state_q;
  flash_state_e state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_sel  = SEL_GAP;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_load = 1'b1;
        tmr_sel  = SEL_LIT;
        cnt_load = 1'b1;
        if (start) state_d = ST_LIT;
      end
      ST_LIT: begin
        tmr_load = tmr_done;
        tmr_sel  = SEL_GAP;
        if (tmr_done) state_d = none_left ? ST_IDLE : ST_GAP;
      end
      ST_GAP: begin
        tmr_load = tmr_done;
        tmr_sel  = SEL_LIT;
        cnt_dec  = tmr_done;
        if (tmr_done) state_d = ST_LIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign light = (state_q == ST_LIT);

  // R2: an idle request enters the lit phase on the next edge
  p_start_lights_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> light);

  // R5: a running lit phase is not cut short by anything but expiry
  p_lit_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIT && !tmr_done) |=> (state_q == ST_LIT));

  // R4: last lit phase goes straight to idle
  p_last_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIT && tmr_done && none_left) |=> (state_q == ST_IDLE));

  // R3: a gap only ends into a lit phase
  p_gap_to_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && tmr_done) |=> light);

  // R1: idle without request stays dark
  p_idle_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> !light);

endmodule

// File: rtl/flash_sequencer.sv
module flash_sequencer #(
  parameter int ON_LOAD     = 5,
  parameter int GAP_LOAD    = 3,
  parameter int NUM_FLASHES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic light
);

  localparam int MAX_LOAD = (ON_LOAD > GAP_LOAD) ? ON_LOAD : GAP_LOAD;
  localparam int TMR_W    = (MAX_LOAD > 0) ? $clog2(MAX_LOAD + 1) : 1;
  localparam int CNT_W    = (NUM_FLASHES > 1) ? $clog2(NUM_FLASHES) : 1;

  logic rst_sync_n;
  logic tmr_load;
  logic tmr_sel;
  logic tmr_done;
  logic cnt_load;
  logic cnt_dec;
  logic none_left;

  flash_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flash_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .tmr_done  (tmr_done),
    .none_left (none_left),
    .tmr_load  (tmr_load),
    .tmr_sel   (tmr_sel),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .light     (light)
  );

  flash_phase_timer #(
    .LIT_LOAD (ON_LOAD),
    .GAP_LOAD (GAP_LOAD),
    .TMR_W    (TMR_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (tmr_load),
    .sel   (tmr_sel),
    .done  (tmr_done)
  );

  flash_left_counter #(
    .NUM_FLASHES (NUM_FLASHES),
    .CNT_W       (CNT_W)
  ) u_left (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (cnt_load),
    .dec       (cnt_dec),
    .none_left (none_left)
  );

  // R9: reset forces the light dark
  p_reset_dark_r9: assert property (@(posedge clk) !rst_n |-> !light);

endmodule

// File: tb/test_flash_sequencer.sv
module test_flash_sequencer;

  localparam int ON_LOAD     = 5;
  localparam int GAP_LOAD    = 3;
  localparam int NUM_FLASHES = 3;
  localparam int ON_CYC      = ON_LOAD + 1;
  localparam int GAP_CYC     = GAP_LOAD + 1;
  localparam int PERIOD      = ON_CYC + GAP_CYC;
  localparam int TOTAL       = NUM_FLASHES * ON_CYC + (NUM_FLASHES - 1) * GAP_CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic light;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 1'b0;
  bit checking = 1'b0;
  string sect  = "R1";

  // Reference model state
  bit m_active = 1'b0;
  int m_k      = 0;

  always #4 clk = ~clk;  // 125 MHz

  flash_sequencer #(
    .ON_LOAD     (ON_LOAD),
    .GAP_LOAD    (GAP_LOAD),
    .NUM_FLASHES (NUM_FLASHES)
  ) i_flash_sequencer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .light (light)
  );

  function automatic bit ref_light(bit act, int k);
    return act && (k < TOTAL) && ((k % PERIOD) < ON_CYC);
  endfunction

  function automatic string ref_tag(bit act, int k);
    if (!act) return "R1";
    if ((k % PERIOD) < ON_CYC) return "R2/R7";
    return "R3/R7/R8";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 1'b0;
      m_k      = 0;
    end else if (m_active) begin
      m_k = m_k + 1;
      if (m_k == TOTAL) m_active = 1'b0;
    end else if (start) begin
      m_active = 1'b1;
      m_k      = 0;
    end
  end

  task automatic check(string tag, bit act_v, bit exp_v);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s [%s] light=%0b expected=%0b at %0t", tag, sect, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) check(ref_tag(m_active, m_k), light, ref_light(m_active, m_k));
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    checking = 1'b0;
    start = 1'b0;
    rst_n = 1'b0;
    cycles(3);
    check("R1", light, 1'b0);
    rst_n = 1'b1;
    cycles(4);
    checking = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    cycles(1);
    do_reset();

    // R1: idle with no request stays dark
    sect = "R1";
    cycles(10);

    // R4: single pulse, full pattern then idle
    sect = "R4";
    start = 1'b1; cycles(1); start = 1'b0;
    cycles(TOTAL + 10);

    // R5: start held high across whole patterns
    sect = "R5";
    start = 1'b1;
    cycles(3 * (TOTAL + 1) + 5);
    start = 1'b0;
    cycles(TOTAL + 2);

    // R6: request on the first idle cycle after a pattern
    sect = "R6";
    start = 1'b1; cycles(1); start = 1'b0;
    while (m_active) cycles(1);
    start = 1'b1; cycles(1); start = 1'b0;
    check("R6", light, 1'b1);
    cycles(TOTAL + 5);

    // R9: asynchronous reset mid-pattern
    sect = "R9";
    start = 1'b1; cycles(1); start = 1'b0;
    cycles(2);
    check("R9", light, 1'b1);
    #2;
    rst_n = 1'b0;
    #1;
    check("R9", light, 1'b0);
    checking = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(4);
    check("R1", light, 1'b0);
    checking = 1'b1;

    // Random pulse trains, R5 mixed in
    sect = "R5";
    for (int i = 0; i < 4000; i++) begin
      start = (($urandom % 6) == 0);
      cycles(1);
    end
    start = 1'b0;
    cycles(TOTAL + 5);

    finish_run();
  end

endmodule